// File: doc/BRIEF.md
# Integer Execute Stage for a Three-Operand RISC Subset

This block is the combinational decode-and-execute step for a small subset of a 32-bit, three-operand RISC instruction set. Each evaluation takes one 32-bit instruction word and the two operand values that the surrounding register file has read for it. From these it produces the result, the destination register number and a write-enable for the register file.

The block handles six operations:

- register-register add, subtract and signed set-less-than;
- left shift of a register by a constant amount;
- add and signed set-less-than against a sign-extended 16-bit constant.

An encoding outside this subset gives no write and raises an illegal-instruction flag. The block has no clock and no state. It sits between operand read and write-back.

Top module: `int_exec_unit`

## Requirements
- R1: A word with opcode bits [31:26] = 0 and funct bits [5:0] = 32 writes rs + rt, wrapping modulo 2^32 with no trap. The destination is the rd field, bits [15:11].
- R2: Opcode 0 with funct 34 writes rs − rt, wrapping modulo 2^32, to rd.
- R3: Opcode 0 with funct 42 writes 1 to rd when rs is less than rt as a signed two's-complement value, and 0 otherwise.
- R4: Opcode 0 with funct 0 writes rt shifted left by the shamt field, bits [10:6], to rd. Zeros are shifted in.
- R5: Opcode 8 writes rs plus the constant in bits [15:0], sign-extended, to the rt field, bits [20:16].
- R6: Opcode 10 writes 1 to rt when rs is less than the sign-extended constant as a signed value, and 0 otherwise.
- R7: An operand whose register field is 0 is used as zero, whatever value is presented on its operand input. The rs field is bits [25:21] and the rt field is bits [20:16].
- R8: When the destination number is 0, write-enable is low. The destination output still shows 0.
- R9: Any other opcode, or opcode 0 with any other funct, sets the illegal flag and drives write-enable low, the result to 0 and the destination to 0.
- R10: The word 0x02324020 decodes as an add with rs = 17, rt = 18 and rd = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value read for the rs field |
| rt_val_i | input | 32 | Value read for the rt field |
| result_o | output | 32 | Computed result |
| dest_o | output | 5 | Destination register number |
| wr_en_o | output | 1 | Register write-enable |
| illegal_o | output | 1 | Unrecognised encoding |

## Verification
The bench targets the following corner cases:

- **Signed compares across the sign boundary.** A design that compared unsigned would report that 0x80000000 is not less than 1.
- **Negative constants in the immediate forms.** Zero-extension would turn −1 into 65535.
- **Wrap at 0x7FFFFFFF + 1 and at 0 − 1.**
- **Shift amounts of 0 and 31.**
- **Destination and operand fields equal to 0.** Unmasked, these would write the zero register or pass through a stale operand value.
- **Near-miss encodings.** These include a funct of 33, opcodes 9 and 11, and opcode 0 with funct 1. A loose decoder would write a result for them instead of raising the illegal flag.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  output logic [DATA_W-1:0] result_o,
  output logic [REG_W-1:0]  dest_o,
  output logic              wr_en_o,
  output logic              illegal_o
);
  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_SLTI = 6'd10;
  localparam logic [5:0] FN_SLL  = 6'd0;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_SLT  = 6'd42;

  wire [5:0]       opc   = instr_i[31:26];
  wire [REG_W-1:0] f_rs  = instr_i[25:21];
  wire [REG_W-1:0] f_rt  = instr_i[20:16];
  wire [REG_W-1:0] f_rd  = instr_i[15:11];
  wire [4:0]       shamt = instr_i[10:6];
  wire [5:0]       funct = instr_i[5:0];
  wire [15:0]      imm   = instr_i[15:0];

  wire [DATA_W-1:0] a     = (f_rs == '0) ? '0 : rs_val_i;
  wire [DATA_W-1:0] b     = (f_rt == '0) ? '0 : rt_val_i;
  wire [DATA_W-1:0] imm_x = {{(DATA_W-16){imm[15]}}, imm};

  logic [DATA_W-1:0] res;
  logic [REG_W-1:0]  dst;
  logic              bad;

  always_comb begin
    res = '0;
    dst = '0;
    bad = 1'b0;
    unique case (opc)
      OP_REG: begin
        dst = f_rd;
        unique case (funct)
          FN_ADD:  res = a + b;
          FN_SUB:  res = a - b;
          FN_SLT:  res = {{(DATA_W-1){1'b0}}, $signed(a) < $signed(b)};
          FN_SLL:  res = b << shamt;
          default: begin bad = 1'b1; dst = '0; end
        endcase
      end
      OP_ADDI: begin
        dst = f_rt;
        res = a + imm_x;
      end
      OP_SLTI: begin
        dst = f_rt;
        res = {{(DATA_W-1){1'b0}}, $signed(a) < $signed(imm_x)};
      end
      default: bad = 1'b1;
    endcase
  end

  assign result_o  = res;
  assign dest_o    = dst;
  assign illegal_o = bad;
  assign wr_en_o   = !bad && (dst != '0);

  always_comb begin
    a_r8_no_zero_write: assert (!(wr_en_o && dest_o == '0));
    a_r9_illegal_quiet: assert (!(illegal_o && (wr_en_o || result_o != '0 || dest_o != '0)));
    if (!illegal_o && (opc == OP_SLTI || (opc == OP_REG && funct == FN_SLT)))
      a_r3_slt_boolean: assert (result_o[DATA_W-1:1] == '0);
    if (!illegal_o && opc != OP_REG)
      a_r5_imm_dest_rt: assert (dest_o == f_rt);
    if (opc == OP_REG && funct == FN_SLL && shamt == 5'd0 && f_rt == '0)
      a_r7_zero_operand: assert (result_o == '0);
  end
endmodule

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] instr, rsv, rtv;
  logic [31:0] result;
  logic [4:0]  dest;
  logic        wr_en, illegal;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_exec_unit uut (
    .instr_i(instr), .rs_val_i(rsv), .rt_val_i(rtv),
    .result_o(result), .dest_o(dest), .wr_en_o(wr_en), .illegal_o(illegal)
  );

  typedef struct { logic [31:0] res; logic [4:0] dst; logic we; logic ill; } exp_t;

  function automatic exp_t model(input logic [31:0] w, input logic [31:0] x, input logic [31:0] y);
    exp_t e;
    int op = w[31:26], fn = w[5:0];
    int rs = w[25:21], rt = w[20:16], rd = w[15:11], sh = w[10:6];
    longint sa, sb, si;
    logic [31:0] va, vb;
    va = (rs == 0) ? 0 : x;
    vb = (rt == 0) ? 0 : y;
    sa = $signed(va); sb = $signed(vb); si = $signed(w[15:0]);
    e.res = 0; e.dst = 0; e.ill = 0;
    if (op == 0 && fn == 32) begin e.res = 32'(sa + sb); e.dst = 5'(rd); end
    else if (op == 0 && fn == 34) begin e.res = 32'(sa - sb); e.dst = 5'(rd); end
    else if (op == 0 && fn == 42) begin e.res = (sa < sb) ? 1 : 0; e.dst = 5'(rd); end
    else if (op == 0 && fn == 0) begin e.res = 32'(longint'(vb) * (longint'(1) << sh)); e.dst = 5'(rd); end
    else if (op == 8) begin e.res = 32'(sa + si); e.dst = 5'(rt); end
    else if (op == 10) begin e.res = (sa < si) ? 1 : 0; e.dst = 5'(rt); end
    else e.ill = 1;
    e.we = !e.ill && e.dst != 0;
    return e;
  endfunction

  function automatic logic [31:0] rw(int fn, int rs, int rt, int rd, int sh);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] iw(int op, int rs, int rt, int k);
    return {6'(op), 5'(rs), 5'(rt), 16'(k)};
  endfunction

  task automatic run(input string tag, input logic [31:0] w, input logic [31:0] x, input logic [31:0] y);
    exp_t e;
    @(posedge clk);
    instr = w; rsv = x; rtv = y;
    e = model(w, x, y);
    @(negedge clk);
    checks++;
    if (result !== e.res || dest !== e.dst || wr_en !== e.we || illegal !== e.ill) begin
      errors++;
      $display("FAIL %s instr=%h got res=%h dst=%0d we=%b ill=%b exp res=%h dst=%0d we=%b ill=%b",
               tag, w, result, dest, wr_en, illegal, e.res, e.dst, e.we, e.ill);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    instr = 32'hFC00_0000; rsv = 0; rtv = 0;
    @(negedge clk);
    checks++;
    if (illegal !== 1'b1 || wr_en !== 1'b0) begin
      errors++;
      $display("FAIL R9 initial illegal=%b we=%b exp 1 0", illegal, wr_en);
    end
    // R10 worked example: rs=17 rt=18 rd=8
    run("R10", 32'h0232_4020, 32'd5, 32'd7);
    checks++;
    if (dest !== 5'd8 || result !== 32'd12) begin
      errors++;
      $display("FAIL R10 dest=%0d res=%0d exp 8 12", dest, result);
    end
    run("R1 wrap",   rw(32, 1, 2, 3, 0), 32'h7FFF_FFFF, 32'd1);
    run("R1 neg",    rw(32, 1, 2, 3, 0), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run("R2 wrap",   rw(34, 4, 5, 6, 0), 32'd0 + 1, 32'd2);
    run("R2 min",    rw(34, 4, 5, 6, 0), 32'h8000_0000, 32'd1);
    run("R3 sign",   rw(42, 1, 2, 9, 0), 32'h8000_0000, 32'd1);
    run("R3 false",  rw(42, 1, 2, 9, 0), 32'd1, 32'h8000_0000);
    run("R3 equal",  rw(42, 1, 2, 9, 0), 32'd7, 32'd7);
    run("R4 sh0",    rw(0, 0, 2, 3, 0), 32'd0, 32'hDEAD_BEEF);
    run("R4 sh31",   rw(0, 0, 2, 3, 31), 32'd0, 32'h0000_0003);
    run("R4 sh4",    rw(0, 7, 2, 3, 4), 32'h1234, 32'h8765_4321);
    run("R5 neg",    iw(8, 1, 7, 16'hFFFF), 32'd10, 32'hAAAA);
    run("R5 min",    iw(8, 1, 7, 16'h8000), 32'd0 + 5, 32'd0);
    run("R5 max",    iw(8, 1, 7, 16'h7FFF), 32'h7FFF_FFFF, 32'd0);
    run("R6 neg",    iw(10, 2, 8, 16'hFFFF), 32'hFFFF_FFFE, 32'd0);
    run("R6 false",  iw(10, 2, 8, 16'hFFFF), 32'd0 + 3, 32'd0);
    run("R7 rs0",    rw(32, 0, 2, 3, 0), 32'hFFFF_0000, 32'd9);
    run("R7 rt0",    rw(32, 4, 0, 3, 0), 32'd9, 32'hFFFF_0000);
    run("R7 move",   iw(8, 0, 5, 16'h0042), 32'h5555_5555, 32'd0);
    run("R8 rd0",    rw(32, 1, 2, 0, 0), 32'd3, 32'd4);
    run("R8 rt0 i",  iw(8, 1, 0, 16'h0001), 32'd3, 32'd0);
    run("R9 fn33",   rw(33, 1, 2, 3, 0), 32'd3, 32'd4);
    run("R9 fn1",    rw(1, 1, 2, 3, 0), 32'd3, 32'd4);
    run("R9 op9",    iw(9, 1, 2, 16'h0001), 32'd3, 32'd4);
    run("R9 op11",   iw(11, 1, 2, 16'h0001), 32'd3, 32'd4);
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 7);
      logic [31:0] w = $urandom;
      if (sel == 0) w[31:26] = 0;
      if (sel == 1) w[31:26] = 8;
      if (sel == 2) w[31:26] = 10;
      if (sel >= 3 && sel <= 6) begin
        w[31:26] = 0;
        w[5:0] = (sel == 3) ? 6'd32 : (sel == 4) ? 6'd34 : (sel == 5) ? 6'd42 : 6'd0;
      end
      run("R1-6 random mix", w, $urandom, $urandom);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule